// File: doc/BRIEF.md
# Descriptor List DMA Walker

This block is the list-processing half of a bus-master network adapter engine. Software builds a list of six-word buffer descriptors in a 16-bit word-addressed memory. It hands the list base to the engine with a start strobe. The engine then walks the list on its own through a request/acknowledge memory port.

For each descriptor the engine takes ownership by stamping the flag word. It stops at the first descriptor whose valid bit is clear, and it jumps to a new list when it meets a chain descriptor. For an ordinary buffer it issues a command to a separate data mover, giving the buffer address, the positive word count and the control bits. When the mover reports completion, the engine writes the returned status into the descriptor and steps to the next one.

Two sticky flags report how the walk ended: list exhausted, or memory fault. An interrupt pulse marks the completion of a buffer that ends a message.

Top module: `dmaListWalker`

## Requirements
- R1: After reset, busy, memReq, memWe, bufCmdValid, listInvalid, nexMem and irq are all low.
- R2: A start pulse while idle loads listBase as the descriptor pointer (a word address), clears listInvalid and nexMem, and begins the walk. A start pulse while busy has no effect on the walk.
- R3: The first access to a descriptor reads its address-high word at pointer+1. The next access writes 16'hC000 (bits 15 and 14 set) to the flag word at pointer+0, whether or not the descriptor is valid.
- R4: If bit 15 of the address-high word is 0, the walk ends. listInvalid is set and stays set, busy falls, no buffer command is issued, and no further memory access happens until the next start.
- R5: If bit 15 and bit 14 of the address-high word are both 1 (chain), the next descriptor pointer becomes {addrHigh[5:0], addrLow}, read from pointer+1 and pointer+2. No buffer command is issued and neither status word is written.
- R6: For a valid, non-chain descriptor, bufCmdValid rises with bufAddr = {addrHigh[5:0], addrLow} and bufWords = the two's-complement negation of the length word at pointer+3. bufCtrl[3:0] = {addrHigh[13] end-of-message, addrHigh[12] setup, addrHigh[7] odd end, addrHigh[6] odd begin}. All of these are held until bufDone.
- R7: The status words are written only after bufDone. bufStatus2 is written to pointer+5 first, then bufStatus1 to pointer+4. Before that, the word at pointer+4 keeps its initial value 16'h8000.
- R8: After the status-one write, the pointer advances by six words and the walk continues with the next descriptor.
- R9: When the status-one write of a descriptor with end-of-message (addrHigh[13]) set is acknowledged, irq is high for exactly one cycle if intEnable is 1. If intEnable is 0, irq stays low.
- R10: memErr on any access ends the walk at once. nexMem is set and stays set, busy falls, and no further access follows.
- R11: While memReq is high and neither memAck nor memErr is returned, memAddr, memWe and memWdata stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk at listBase (accepted only while idle) |
| listBase | input | 22 | Word address of the first descriptor |
| intEnable | input | 1 | Allows irq pulses |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 22 | Word address of the access |
| memWdata | output | 16 | Write data |
| memAck | input | 1 | Access completed; read data valid this cycle |
| memErr | input | 1 | Access failed (no memory at address) |
| memRdata | input | 16 | Read data |
| bufCmdValid | output | 1 | Buffer command active until bufDone |
| bufAddr | output | 22 | Buffer byte address |
| bufWords | output | 16 | Positive buffer length in words |
| bufCtrl | output | 4 | {end-of-message, setup, odd end, odd begin} |
| bufDone | input | 1 | Data mover finished the buffer |
| bufStatus1 | input | 16 | Status word one to store |
| bufStatus2 | input | 16 | Status word two to store |
| busy | output | 1 | Walk in progress |
| listInvalid | output | 1 | Sticky: walk ended on an invalid descriptor |
| nexMem | output | 1 | Sticky: walk ended on a memory error |
| irq | output | 1 | One-cycle end-of-message completion pulse |

## Verification
Memory accesses complete in the cycle their acknowledge is sampled, so the bench memory logs each write at the clock edge where it is acknowledged. Wait states from the memory stretch the timing, and the checks do not depend on exact cycle counts. The buffer command is sampled at a falling edge once bufCmdValid is seen, and the status word at pointer+4 is read at that moment to confirm it is still untouched. irq is due one cycle after the status-one acknowledge, and it is counted at every rising edge. busy falls in the cycle after the final flag write or the erroring access. Final memory contents and the flags are checked only after the bench has seen busy low at a falling edge.

// File: rtl/dlw_pkg.sv
package dlw_pkg;
  localparam int DESC_WORDS = 6;
  localparam int OFS_FLAG   = 0;
  localparam int OFS_HI     = 1;
  localparam int OFS_LO     = 2;
  localparam int OFS_LEN    = 3;
  localparam int OFS_ST1    = 4;
  localparam int OFS_ST2    = 5;
  localparam logic [15:0] FLAG_SEEN = 16'hC000;
  localparam int BIT_VALID  = 15;
  localparam int BIT_CHAIN  = 14;
  localparam int BIT_EOM    = 13;
  localparam int BIT_SETUP  = 12;
  localparam int BIT_ODDEND = 7;
  localparam int BIT_ODDBEG = 6;

  typedef enum logic [1:0] {WD_FLAG, WD_ST1, WD_ST2} wdSel_e;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_HI, S_WR_FLAG, S_RD_LO, S_RD_LEN, S_BUF, S_WR_ST2, S_WR_ST1
  } walkState_e;

  typedef struct packed {
    logic       loadPtr;
    logic       capHi;
    logic       capLo;
    logic       capLen;
    logic       capStatus;
    logic       chainPtr;
    logic       advancePtr;
    logic [2:0] wordSel;
    wdSel_e     wdSel;
  } ctlStrobes_t;
endpackage

// File: rtl/dlwDatapath.sv
module dlwDatapath
  import dlw_pkg::*;
#(
  parameter int AW = 22,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobes_t   strobes,
  input  logic [AW-1:0] listBase,
  input  logic [DW-1:0] memRdata,
  input  logic [DW-1:0] bufStatus1,
  input  logic [DW-1:0] bufStatus2,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  output logic [AW-1:0] bufAddr,
  output logic [DW-1:0] bufWords,
  output logic [3:0]    bufCtrl,
  output logic          validBit,
  output logic          chainBit,
  output logic          eomBit
);
  localparam int HI_BITS = AW - DW;

  logic [AW-1:0] descPtr;
  logic [DW-1:0] hiWord, loWord, lenWord, stat1, stat2;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      descPtr <= '0;
      hiWord  <= '0;
      loWord  <= '0;
      lenWord <= '0;
      stat1   <= '0;
      stat2   <= '0;
    end else begin
      if (strobes.loadPtr)    descPtr <= listBase;
      if (strobes.advancePtr) descPtr <= descPtr + AW'(DESC_WORDS);
      if (strobes.chainPtr)   descPtr <= {hiWord[HI_BITS-1:0], memRdata};
      if (strobes.capHi)      hiWord  <= memRdata;
      if (strobes.capLo)      loWord  <= memRdata;
      if (strobes.capLen)     lenWord <= memRdata;
      if (strobes.capStatus) begin
        stat1 <= bufStatus1;
        stat2 <= bufStatus2;
      end
    end
  end

  assign memAddr = descPtr + AW'(strobes.wordSel);

  always_comb begin
    unique case (strobes.wdSel)
      WD_ST1:  memWdata = stat1;
      WD_ST2:  memWdata = stat2;
      default: memWdata = FLAG_SEEN;
    endcase
  end

  assign bufAddr  = {hiWord[HI_BITS-1:0], loWord};
  assign bufWords = DW'(0) - lenWord;
  assign bufCtrl  = {hiWord[BIT_EOM], hiWord[BIT_SETUP],
                     hiWord[BIT_ODDEND], hiWord[BIT_ODDBEG]};
  assign validBit = hiWord[BIT_VALID];
  assign chainBit = hiWord[BIT_CHAIN];
  assign eomBit   = hiWord[BIT_EOM];
endmodule

// File: rtl/dlwControl.sv
module dlwControl
  import dlw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        intEnable,
  input  logic        memAck,
  input  logic        memErr,
  input  logic        bufDone,
  input  logic        validBit,
  input  logic        chainBit,
  input  logic        eomBit,
  output ctlStrobes_t strobes,
  output logic        memReq,
  output logic        memWe,
  output logic        bufCmdValid,
  output logic        busy,
  output logic        listInvalid,
  output logic        nexMem,
  output logic        irq
);
  walkState_e state, nextState;
  logic memOk;

  assign memOk       = memAck && !memErr;
  assign memReq      = state inside {S_RD_HI, S_WR_FLAG, S_RD_LO, S_RD_LEN, S_WR_ST2, S_WR_ST1};
  assign memWe       = state inside {S_WR_FLAG, S_WR_ST2, S_WR_ST1};
  assign bufCmdValid = (state == S_BUF);
  assign busy        = (state != S_IDLE);

  always_comb begin
    strobes   = '0;
    nextState = state;
    unique case (state)
      S_IDLE: if (start) begin
        strobes.loadPtr = 1'b1;
        nextState       = S_RD_HI;
      end
      S_RD_HI: begin
        strobes.wordSel = 3'(OFS_HI);
        if (memOk) begin
          strobes.capHi = 1'b1;
          nextState     = S_WR_FLAG;
        end
      end
      S_WR_FLAG: begin
        strobes.wordSel = 3'(OFS_FLAG);
        strobes.wdSel   = WD_FLAG;
        if (memOk) nextState = validBit ? S_RD_LO : S_IDLE;
      end
      S_RD_LO: begin
        strobes.wordSel = 3'(OFS_LO);
        if (memOk) begin
          if (chainBit) begin
            strobes.chainPtr = 1'b1;
            nextState        = S_RD_HI;
          end else begin
            strobes.capLo = 1'b1;
            nextState     = S_RD_LEN;
          end
        end
      end
      S_RD_LEN: begin
        strobes.wordSel = 3'(OFS_LEN);
        if (memOk) begin
          strobes.capLen = 1'b1;
          nextState      = S_BUF;
        end
      end
      S_BUF: if (bufDone) begin
        strobes.capStatus = 1'b1;
        nextState         = S_WR_ST2;
      end
      S_WR_ST2: begin
        strobes.wordSel = 3'(OFS_ST2);
        strobes.wdSel   = WD_ST2;
        if (memOk) nextState = S_WR_ST1;
      end
      S_WR_ST1: begin
        strobes.wordSel = 3'(OFS_ST1);
        strobes.wdSel   = WD_ST1;
        if (memOk) begin
          strobes.advancePtr = 1'b1;
          nextState          = S_RD_HI;
        end
      end
      default: nextState = S_IDLE;
    endcase
    if (memReq && memErr) nextState = S_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= S_IDLE;
      listInvalid <= 1'b0;
      nexMem      <= 1'b0;
      irq         <= 1'b0;
    end else begin
      state <= nextState;
      irq   <= (state == S_WR_ST1) && memOk && eomBit && intEnable;
      if (state == S_IDLE && start) begin
        listInvalid <= 1'b0;
        nexMem      <= 1'b0;
      end
      if (state == S_WR_FLAG && memOk && !validBit) listInvalid <= 1'b1;
      if (memReq && memErr) nexMem <= 1'b1;
    end
  end

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck && !memErr |=> memReq && $stable(memWe) && $stable(strobes.wordSel));

  // R9
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);

  // R4
  invalid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(listInvalid) |-> !busy && !memReq);

  // R10
  nexmem_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nexMem) |-> $past(memErr) && !busy);
endmodule

// File: rtl/dmaListWalker.sv
module dmaListWalker
  import dlw_pkg::*;
#(
  parameter int AW = 22,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [AW-1:0] listBase,
  input  logic          intEnable,
  output logic          memReq,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  input  logic          memAck,
  input  logic          memErr,
  input  logic [DW-1:0] memRdata,
  output logic          bufCmdValid,
  output logic [AW-1:0] bufAddr,
  output logic [DW-1:0] bufWords,
  output logic [3:0]    bufCtrl,
  input  logic          bufDone,
  input  logic [DW-1:0] bufStatus1,
  input  logic [DW-1:0] bufStatus2,
  output logic          busy,
  output logic          listInvalid,
  output logic          nexMem,
  output logic          irq
);
  ctlStrobes_t strobes;
  logic validBit, chainBit, eomBit;

  dlwControl i_control (
    .clk, .rstN, .start, .intEnable, .memAck, .memErr, .bufDone,
    .validBit, .chainBit, .eomBit, .strobes, .memReq, .memWe,
    .bufCmdValid, .busy, .listInvalid, .nexMem, .irq
  );

  dlwDatapath #(.AW(AW), .DW(DW)) i_datapath (
    .clk, .rstN, .strobes, .listBase, .memRdata, .bufStatus1, .bufStatus2,
    .memAddr, .memWdata, .bufAddr, .bufWords, .bufCtrl,
    .validBit, .chainBit, .eomBit
  );

  // R11
  mem_data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck && !memErr |=> $stable(memAddr) && $stable(memWdata));

  // R6
  buf_cmd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    bufCmdValid && !bufDone |=> bufCmdValid && $stable(bufAddr)
                                && $stable(bufWords) && $stable(bufCtrl));
endmodule

// File: tb/test_dmaListWalker.sv
module test_dmaListWalker;
  localparam int AW = 22;
  localparam int DW = 16;
  localparam int MEMW = 256;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, intEnable = 1'b0;
  logic [AW-1:0] listBase = '0;
  logic memReq, memWe, memAck, memErr;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata, memRdata;
  logic bufCmdValid, bufDone = 1'b0;
  logic [AW-1:0] bufAddr;
  logic [DW-1:0] bufWords, bufStatus1 = '0, bufStatus2 = '0;
  logic [3:0] bufCtrl;
  logic busy, listInvalid, nexMem, irq;

  always #2.5 clk = ~clk;

  dmaListWalker i_dmaListWalker (.*);

  logic [15:0] mem [MEMW];
  logic stall = 1'b0, stallEn = 1'b0;
  int cyc = 0;
  logic inRange;
  assign inRange  = memAddr < AW'(MEMW);
  assign memAck   = memReq && inRange && !stall;
  assign memErr   = memReq && !inRange;
  assign memRdata = inRange ? mem[memAddr[7:0]] : 16'h0;

  int wrCount = 0, bufCount = 0, irqCount = 0, moverCnt = 0;
  logic [21:0] wrAddr [16];
  logic [15:0] wrData [16];
  logic [21:0] logAddr [8];
  logic [15:0] logWords [8];
  logic [3:0]  logCtrl [8];
  logic [15:0] st1Seen;
  int st1Loc = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (irq) irqCount <= irqCount + 1;
    if (memReq && memWe && memAck) begin
      mem[memAddr[7:0]] <= memWdata;
      if (wrCount < 16) begin
        wrAddr[wrCount] <= memAddr;
        wrData[wrCount] <= memWdata;
      end
      wrCount <= wrCount + 1;
    end
  end

  always @(negedge clk) begin
    stall <= stallEn && (cyc % 3 == 1);
    if (bufDone) bufDone <= 1'b0;
    else if (bufCmdValid) begin
      if (moverCnt == 0) st1Seen <= mem[st1Loc];
      if (moverCnt == 2) begin
        bufDone    <= 1'b1;
        bufStatus1 <= 16'h0100 + 16'(bufCount);
        bufStatus2 <= 16'h0A00 + 16'(bufCount);
        if (bufCount < 8) begin
          logAddr[bufCount]  <= bufAddr;
          logWords[bufCount] <= bufWords;
          logCtrl[bufCount]  <= bufCtrl;
        end
        bufCount <= bufCount + 1;
        moverCnt <= 0;
      end else moverCnt <= moverCnt + 1;
    end
  end

  int checks = 0, failures = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < MEMW; i++) mem[i] = 16'h0;
  endtask

  task automatic putDesc(input int base, input logic [15:0] hi, input logic [15:0] lo,
                         input logic [15:0] len);
    mem[base]   = 16'h0;
    mem[base+1] = hi;
    mem[base+2] = lo;
    mem[base+3] = len;
    mem[base+4] = 16'h8000;
    mem[base+5] = 16'h0;
  endtask

  task automatic resetLogs();
    wrCount = 0; bufCount = 0; irqCount = 0;
  endtask

  task automatic pulseStart(input logic [AW-1:0] base);
    @(negedge clk);
    listBase = base;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitIdle();
    for (int n = 0; n < 5000 && busy; n++) @(negedge clk);
  endtask

  // {addrHigh, addrLow, length word, expected words, expected ctrl}
  localparam logic [67:0] VEC [4] = '{
    {16'h8000, 16'h1234, 16'hFFFF, 16'h0001, 4'h0},
    {16'hA0C5, 16'h0010, 16'hFFC0, 16'h0040, 4'hB},
    {16'h903F, 16'hFFFE, 16'h8000, 16'h8000, 4'h4},
    {16'hB0C1, 16'hABCD, 16'hFFFE, 16'h0002, 4'hF}
  };

  initial begin
    clearMem();
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !memReq && !memWe && !bufCmdValid, "R1", "idle outputs in reset",
          {busy, memReq, memWe, bufCmdValid}, 0);
    check(!listInvalid && !nexMem && !irq, "R1", "flags in reset",
          {listInvalid, nexMem, irq}, 0);
    rstN = 1'b1;
    intEnable = 1'b1;
    @(negedge clk);
    check(!busy && !memReq, "R1", "idle after reset release", {busy, memReq}, 0);

    // Table-driven single-buffer walks
    for (int v = 0; v < 4; v++) begin
      logic [15:0] hi, lo, len, ew;
      logic [3:0] ec;
      {hi, lo, len, ew, ec} = VEC[v];
      clearMem();
      putDesc(8, hi, lo, len);
      putDesc(14, 16'h0000, 16'h0, 16'h0);
      st1Loc = 12;
      stallEn = (v == 2);
      resetLogs();
      pulseStart(22'd8);
      check(busy, "R2", "busy after start", busy, 1);
      waitIdle();
      check(bufCount == 1, "R6", "one buffer command", bufCount, 1);
      check(logAddr[0] == {hi[5:0], lo}, "R6", "buffer address", logAddr[0], {hi[5:0], lo});
      check(logWords[0] == ew, "R6", "word count", logWords[0], ew);
      check(logCtrl[0] == ec, "R6", "control bits", logCtrl[0], ec);
      check(st1Seen == 16'h8000, "R7", "status1 untouched during buffer", st1Seen, 16'h8000);
      check(wrCount == 4, "R7", "write count", wrCount, 4);
      check(wrAddr[0] == 8 && wrData[0] == 16'hC000, "R3", "flag stamp first write",
            {wrAddr[0][15:0], wrData[0]}, {16'd8, 16'hC000});
      check(wrAddr[1] == 13 && wrAddr[2] == 12, "R7", "status2 then status1 order",
            {wrAddr[1][15:0], wrAddr[2][15:0]}, {16'd13, 16'd12});
      check(mem[12] == 16'h0100 && mem[13] == 16'h0A00, "R7", "status values",
            {mem[12], mem[13]}, {16'h0100, 16'h0A00});
      check(wrAddr[3] == 14 && mem[14] == 16'hC000, "R8", "next descriptor at +6 stamped",
            {wrAddr[3][15:0], mem[14]}, {16'd14, 16'hC000});
      check(listInvalid && !nexMem, "R4", "list invalid at end", {listInvalid, nexMem}, 2'b10);
      check(irqCount == int'(ec[3]), "R9", "irq pulses with intEnable", irqCount, ec[3]);
    end
    stallEn = 1'b0;

    // R4 flag stays set while idle; walk does not restart
    repeat (5) @(negedge clk);
    check(listInvalid && !busy && !memReq, "R4", "sticky invalid, no access",
          {listInvalid, busy, memReq}, 3'b100);

    // R5 chain then buffer
    clearMem();
    putDesc(30, 16'hC000, 16'h0040, 16'h0);
    putDesc(64, 16'h8000, 16'h0100, 16'hFFFC);
    putDesc(70, 16'h0000, 16'h0, 16'h0);
    st1Loc = 68;
    resetLogs();
    pulseStart(22'd30);
    check(!listInvalid, "R2", "start clears listInvalid", listInvalid, 0);
    waitIdle();
    check(bufCount == 1 && logAddr[0] == 22'h100 && logWords[0] == 4, "R5",
          "buffer after chain", {bufCount[7:0], logAddr[0][15:0], logWords[0][7:0]},
          {8'd1, 16'h0100, 8'd4});
    check(mem[34] == 16'h8000 && mem[35] == 16'h0, "R5", "chain status untouched",
          {mem[34], mem[35]}, {16'h8000, 16'h0});
    check(mem[30] == 16'hC000 && mem[64] == 16'hC000, "R3", "chain and target stamped",
          {mem[30], mem[64]}, {16'hC000, 16'hC000});
    check(mem[68] == 16'h0100 && mem[70] == 16'hC000 && listInvalid, "R8",
          "after chained buffer", {mem[68], mem[70]}, {16'h0100, 16'hC000});

    // R10 memory error at start address
    resetLogs();
    pulseStart(22'd300);
    waitIdle();
    check(nexMem && !busy && !listInvalid, "R10", "nexMem on error",
          {nexMem, busy, listInvalid}, 3'b100);
    check(wrCount == 0 && bufCount == 0, "R10", "no access after error",
          {wrCount[15:0], bufCount[15:0]}, 0);
    repeat (4) @(negedge clk);
    check(nexMem && !memReq, "R10", "nexMem sticky", {nexMem, memReq}, 2'b10);

    // R2 start while busy ignored; R9 eom with interrupts disabled
    clearMem();
    putDesc(40, 16'hA000, 16'h0200, 16'hFFF8);
    putDesc(46, 16'h0000, 16'h0, 16'h0);
    st1Loc = 44;
    intEnable = 1'b0;
    resetLogs();
    pulseStart(22'd40);
    check(!nexMem, "R2", "start clears nexMem", nexMem, 0);
    for (int n = 0; n < 100 && !bufCmdValid; n++) @(negedge clk);
    listBase = 22'd300;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitIdle();
    check(!nexMem && listInvalid && bufCount == 1, "R2", "start during walk ignored",
          {nexMem, listInvalid, bufCount[7:0]}, {1'b0, 1'b1, 8'd1});
    check(logWords[0] == 8 && logCtrl[0] == 4'h8, "R6", "eom buffer command",
          {logWords[0], 12'h0, logCtrl[0]}, {16'd8, 16'h0008});
    check(irqCount == 0, "R9", "no irq when disabled", irqCount, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule